// File: doc/BRIEF.md
# Fly-by DMA Channel

This block is one direct-memory-access channel for transfers where the data skips the controller entirely. An external peripheral asks for service by holding a request line high. The channel answers with an acknowledge strobe that selects that peripheral. In the same bus cycle it drives an address and a read or write strobe toward the other party, which is an external memory or a memory-mapped device. The peripheral and the addressed party then exchange the data word directly on the shared data bus. The channel never samples or drives that bus, so each unit of data costs exactly one bus cycle.

Software programs the channel through a small word-wide register port. The port holds an address register, a transfer counter and a control word. The control word sets the enable, the direction, the transfer unit size, the address-stepping mode and the interrupt enable, and it reports the done flag. Only the external request line can start a transfer. When the counter reaches zero the channel disables itself and sets the done flag, which can drive the interrupt output.

Top module: `flyby_dma`

## Requirements
- R1: After reset, `dack`, `bus_cyc`, `mem_rd`, `mem_wr`, `done` and `irq` are low, and the address, count and control registers all read as zero.
- R2: Each unit moves in one bus cycle. During that cycle `dack` and `bus_cyc` are high together for exactly CYC_LEN clocks, with exactly one of `mem_rd` or `mem_wr` asserted, and `bus_addr` holds the address register for the whole cycle.
- R3: Control bit 1 sets the direction. A value of 0 means peripheral to memory, and the cycle asserts `mem_wr`. A value of 1 means memory to peripheral, and the cycle asserts `mem_rd`.
- R4: The address register updates at the end of each cycle according to the mode field (control bits 5:4) and the size field (control bits 3:2). Mode 1 adds the unit size, mode 2 subtracts it, and modes 0 and 3 leave the address unchanged. Size codes 0, 1 and 2 give 1, 2 and 4 bytes, and size code 3 also gives 4 bytes.
- R5: The count register (select 1) drops by one per cycle. The cycle that brings it to zero clears the enable (control bit 0) and sets done (control bit 7), and no further cycle follows.
- R6: The channel samples `dreq` at the end of each cycle. If `dreq` is low there, no further cycle starts, and the count, address and enable keep their values. A later `dreq` resumes the transfer from the next address.
- R7: `dack` is low for at least one clock between two consecutive bus cycles.
- R8: While the enable is 0 or the count is 0, a high `dreq` starts no cycle and does not set done.
- R9: `irq` equals done AND the interrupt enable (control bit 6). Writing the control word (select 2) with bit 7 set clears done.
- R10: Writes to the address register (select 0) or the count register (select 1) are ignored while a bus cycle or the gap after it is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 control |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for the selected register |
| dreq | input | 1 | Level-sensitive transfer request from the peripheral |
| dack | output | 1 | Acknowledge strobe that selects the peripheral |
| bus_addr | output | ADDR_W | Address toward the memory side |
| bus_cyc | output | 1 | Bus cycle active strobe |
| mem_rd | output | 1 | Memory-side read strobe |
| mem_wr | output | 1 | Memory-side write strobe |
| done | output | 1 | Transfer complete flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench watches for a dropped request, which a wrong design would either ignore by running another cycle or mishandle by losing the count or the address. It counts the clocks that `dack` is high in every cycle and checks the gap between cycles. It also checks the last-cycle boundary, where a wrong counter would run one cycle too many or never raise done. It covers the odd size code and the fixed and decrement modes, where a wrong step function gives the wrong address sequence. It also writes the address and count registers while a burst is running, which a design without the busy guard would let corrupt the burst.

// File: rtl/flyby_pkg.sv
package flyby_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_GAP  = 2'd2
  } fb_state_e;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  localparam logic [1:0] AM_FIXED = 2'd0;
  localparam logic [1:0] AM_INC   = 2'd1;
  localparam logic [1:0] AM_DEC   = 2'd2;

  typedef struct packed {
    logic       irq_en;
    logic [1:0] mode;
    logic [1:0] size;
    logic       dir;
    logic       en;
  } ctrl_t;

  // bytes moved per cycle for a size code; code 3 is treated as 4 bytes
  function automatic logic [31:0] unit_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 32'd1;
      2'd1:    return 32'd2;
      default: return 32'd4;
    endcase
  endfunction

  // address after one cycle for a given size and stepping mode
  function automatic logic [31:0] next_addr(input logic [31:0] a,
                                            input logic [1:0]  sz,
                                            input logic [1:0]  mode);
    case (mode)
      AM_INC:  return a + unit_bytes(sz);
      AM_DEC:  return a - unit_bytes(sz);
      default: return a;
    endcase
  endfunction

endpackage

// File: rtl/flyby_step.sv
module flyby_step #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [1:0]        size,
  input  logic [1:0]        mode,
  output logic [ADDR_W-1:0] addr_nxt
);
  logic [31:0] wide_cur;
  logic [31:0] wide_nxt;

  always_comb begin
    wide_cur = 32'(addr_q);
    wide_nxt = flyby_pkg::next_addr(wide_cur, size, mode);
    addr_nxt = wide_nxt[ADDR_W-1:0];
  end
endmodule

// File: rtl/flyby_seq.sv
module flyby_seq #(
  parameter int CYC_LEN = 2,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dreq,
  input  logic             en,
  input  logic             dir,
  input  logic [CNT_W-1:0] cnt_q,
  output logic             dack,
  output logic             bus_cyc,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             cyc_end,
  output logic             busy,
  output logic             launch
);
  import flyby_pkg::*;

  localparam int WC_W = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;
  localparam logic [WC_W-1:0] LAST_BEAT = WC_W'(CYC_LEN - 1);

  fb_state_e       state_q, state_d;
  logic [WC_W-1:0] beat_q;
  logic            dir_q;
  logic            last_beat;
  logic            more;
  logic            resume;

  assign last_beat = (beat_q == LAST_BEAT);
  assign cyc_end   = (state_q == ST_BUS) && last_beat;
  assign launch    = (state_q == ST_IDLE) && en && dreq && (cnt_q != '0);
  assign resume    = (state_q == ST_GAP) && en && (cnt_q != '0);
  // another cycle follows only if the request holds and units remain after this one
  assign more      = dreq && en && (cnt_q != CNT_W'(1));

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (launch) state_d = ST_BUS;
      ST_BUS:  if (last_beat) state_d = more ? ST_GAP : ST_IDLE;
      ST_GAP:  state_d = resume ? ST_BUS : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      dir_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_BUS && !last_beat) beat_q <= beat_q + 1'b1;
      else                                 beat_q <= '0;
      if (launch || resume) dir_q <= dir;
    end
  end

  assign dack    = (state_q == ST_BUS);
  assign bus_cyc = (state_q == ST_BUS);
  assign mem_wr  = (state_q == ST_BUS) && !dir_q;
  assign mem_rd  = (state_q == ST_BUS) && dir_q;
  assign busy    = (state_q != ST_IDLE);
endmodule

// File: rtl/flyby_regs.sv
module flyby_regs #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              busy,
  input  logic              cyc_end,
  input  logic [ADDR_W-1:0] addr_nxt,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CNT_W-1:0]  cnt_q,
  output flyby_pkg::ctrl_t  ctrl_q,
  output logic              done_q
);
  import flyby_pkg::*;

  logic final_unit;
  assign final_unit = cyc_end && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (cyc_end) begin
        addr_q <= addr_nxt;
        cnt_q  <= cnt_q - 1'b1;
      end
      if (final_unit) begin
        ctrl_q.en <= 1'b0;
        done_q    <= 1'b1;
      end
      if (cfg_we) begin
        case (cfg_sel)
          SEL_ADDR: if (!busy) addr_q <= cfg_wdata[ADDR_W-1:0];
          SEL_CNT:  if (!busy) cnt_q  <= cfg_wdata[CNT_W-1:0];
          SEL_CTRL: begin
            ctrl_q <= cfg_wdata[6:0];
            if (cfg_wdata[7]) done_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (cfg_sel)
      SEL_ADDR: cfg_rdata = 32'(addr_q);
      SEL_CNT:  cfg_rdata = 32'(cnt_q);
      SEL_CTRL: cfg_rdata = {24'd0, done_q, ctrl_q};
      default:  cfg_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/flyby_dma.sv
module flyby_dma #(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 16,
  parameter int CYC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              dreq,
  output logic              dack,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_cyc,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              done,
  output logic              irq
);
  import flyby_pkg::*;

  ctrl_t             ctrl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_nxt;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q;
  logic              cyc_end;
  logic              busy;
  logic              launch;
  logic              en_w;

  assign en_w = ctrl_q.en;

  flyby_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy),
    .cyc_end(cyc_end), .addr_nxt(addr_nxt), .addr_q(addr_q),
    .cnt_q(cnt_q), .ctrl_q(ctrl_q), .done_q(done_q)
  );

  flyby_step #(.ADDR_W(ADDR_W)) u_step (
    .addr_q(addr_q), .size(ctrl_q.size), .mode(ctrl_q.mode),
    .addr_nxt(addr_nxt)
  );

  flyby_seq #(.CYC_LEN(CYC_LEN), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .dreq(dreq), .en(ctrl_q.en),
    .dir(ctrl_q.dir), .cnt_q(cnt_q), .dack(dack), .bus_cyc(bus_cyc),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .cyc_end(cyc_end), .busy(busy),
    .launch(launch)
  );

  assign bus_addr = addr_q;
  assign done     = done_q;
  assign irq      = done_q && ctrl_q.irq_en;
endmodule

// File: rtl/flyby_dma_chk.sv
module flyby_dma_chk #(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 16,
  parameter int CYC_LEN = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dreq,
  input logic              dack,
  input logic              bus_cyc,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              cyc_end,
  input logic              done,
  input logic              en,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [ADDR_W-1:0] bus_addr
);
  logic [15:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (dack) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  p_strobes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> bus_cyc && (mem_rd != mem_wr));

  p_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> (32'(run_q) < CYC_LEN));

  p_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |-> (32'(run_q) == CYC_LEN - 1));

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dack && $past(dack) |-> $stable(bus_addr));

  p_dir_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dack && $past(dack) |-> $stable(mem_rd) && $stable(mem_wr));

  p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));

  p_done_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (cnt_q == '0) && !en);

  p_req_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dack) |-> $past(dreq) || $past(dreq, 2));

  p_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> !dack);

  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || cnt_q == '0) && !dack |=> !dack);
endmodule

bind flyby_dma flyby_dma_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CYC_LEN(CYC_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .dreq(dreq), .dack(dack), .bus_cyc(bus_cyc),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .cyc_end(cyc_end), .done(done),
  .en(en_w), .cnt_q(cnt_q), .bus_addr(bus_addr)
);

// File: tb/sim_flyby_dma.sv
`timescale 1ns/1ps
module sim_flyby_dma;
  localparam int ADDR_W  = 32;
  localparam int CNT_W   = 16;
  localparam int CYC_LEN = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [1:0]        cfg_sel = 2'd0;
  logic [31:0]       cfg_wdata = 32'd0;
  logic [31:0]       cfg_rdata;
  logic              dreq = 1'b0;
  logic              dack;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_cyc;
  logic              mem_rd;
  logic              mem_wr;
  logic              done;
  logic              irq;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  flyby_dma #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CYC_LEN(CYC_LEN)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dreq(dreq), .dack(dack),
    .bus_addr(bus_addr), .bus_cyc(bus_cyc), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .done(done), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] sel, output logic [31:0] data);
    @(negedge clk);
    cfg_sel = sel;
    #1 data = cfg_rdata;
  endtask

  // leaves the caller at the negedge where dack is first seen high
  task automatic wait_dack(input string req, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (dack) begin seen = 1'b1; break; end
    end
    if (!seen) check(1'b0, req, "dack never rose", 32'd0, 32'd1);
  endtask

  // counts high negedges from the current one, returns at the first low one
  task automatic measure_high(output int n);
    n = 1;
    forever begin
      @(negedge clk);
      if (dack) n++;
      else break;
    end
  endtask

  task automatic watch_cycles(input int n, input logic [31:0] start,
                              input logic [31:0] step, input bit rd,
                              input string req);
    logic [31:0] exp = start;
    bit seen;
    int hi;
    for (int k = 0; k < n; k++) begin
      wait_dack(req, seen);
      if (!seen) return;
      check(bus_addr == exp, req, "cycle address", bus_addr, exp);
      check(mem_rd == rd && mem_wr == !rd && bus_cyc, "R3", "strobe pattern",
            {29'd0, bus_cyc, mem_rd, mem_wr}, {29'd0, 1'b1, rd, !rd});
      measure_high(hi);
      check(hi == CYC_LEN, "R2", "dack length", hi, CYC_LEN);
      exp = exp + step;
    end
  endtask

  task automatic expect_quiet(input int clocks, input string req);
    int hits = 0;
    for (int i = 0; i < clocks; i++) begin
      @(negedge clk);
      if (dack) hits++;
    end
    check(hits == 0, req, "dack while idle", hits, 0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check(!dack && !bus_cyc && !mem_rd && !mem_wr, "R1", "strobes at reset",
          {28'd0, dack, bus_cyc, mem_rd, mem_wr}, 32'd0);
    check(!done && !irq, "R1", "done/irq at reset", {30'd0, done, irq}, 32'd0);
    cfg_read(2'd0, v); check(v == 0, "R1", "address reg", v, 0);
    cfg_read(2'd1, v); check(v == 0, "R1", "count reg", v, 0);
    cfg_read(2'd2, v); check(v == 0, "R1", "control reg", v, 0);
  endtask

  task automatic t_inc_write();
    logic [31:0] v;
    cfg_write(2'd0, 32'h1000);
    cfg_write(2'd1, 32'd3);
    dreq = 1'b1;
    cfg_write(2'd2, 32'h59);   // en, dir 0, size 4B, increment, irq enable
    watch_cycles(3, 32'h1000, 32'd4, 1'b0, "R4");
    check(done, "R5", "done after last", done, 1);
    check(irq, "R9", "irq with enable", irq, 1);
    expect_quiet(10, "R5");
    cfg_read(2'd1, v); check(v == 0, "R5", "count at end", v, 0);
    cfg_read(2'd2, v); check(v[0] == 1'b0 && v[7], "R5", "en cleared/done set", v, 32'hD8);
    cfg_read(2'd0, v); check(v == 32'h100C, "R4", "final address", v, 32'h100C);
    dreq = 1'b0;
    cfg_write(2'd2, 32'h80);
    @(negedge clk);
    check(!done && !irq, "R9", "done cleared", {30'd0, done, irq}, 0);
  endtask

  task automatic t_dec_read();
    logic [31:0] v;
    cfg_write(2'd0, 32'h2000);
    cfg_write(2'd1, 32'd4);
    dreq = 1'b1;
    cfg_write(2'd2, 32'h27);   // en, dir 1, size 2B, decrement
    watch_cycles(4, 32'h2000, 32'hFFFF_FFFE, 1'b1, "R4");
    @(negedge clk);
    check(done && !irq, "R9", "irq gated off", {30'd0, done, irq}, 32'd2);
    cfg_read(2'd0, v); check(v == 32'h1FF8, "R4", "decremented address", v, 32'h1FF8);
    dreq = 1'b0;
    cfg_write(2'd2, 32'h80);
  endtask

  task automatic t_modes();
    logic [31:0] v;
    cfg_write(2'd0, 32'h3003);
    cfg_write(2'd1, 32'd2);
    dreq = 1'b1;
    cfg_write(2'd2, 32'h01);   // fixed mode 0
    watch_cycles(2, 32'h3003, 32'd0, 1'b0, "R4");
    cfg_read(2'd0, v); check(v == 32'h3003, "R4", "fixed mode 0", v, 32'h3003);
    cfg_write(2'd1, 32'd2);
    cfg_write(2'd2, 32'hB1);   // clear done, mode 3 holds
    watch_cycles(2, 32'h3003, 32'd0, 1'b0, "R4");
    cfg_read(2'd0, v); check(v == 32'h3003, "R4", "fixed mode 3", v, 32'h3003);
    cfg_write(2'd0, 32'h40);
    cfg_write(2'd1, 32'd2);
    cfg_write(2'd2, 32'h9D);   // clear done, size code 3, increment
    watch_cycles(2, 32'h40, 32'd4, 1'b0, "R4");
    cfg_read(2'd0, v); check(v == 32'h48, "R4", "size code 3 step", v, 32'h48);
    dreq = 1'b0;
    cfg_write(2'd2, 32'h80);
  endtask

  task automatic t_req_drop();
    logic [31:0] v;
    bit seen;
    int hi;
    cfg_write(2'd0, 32'h500);
    cfg_write(2'd1, 32'd5);
    dreq = 1'b1;
    cfg_write(2'd2, 32'h15);   // en, size 2B, increment
    wait_dack("R6", seen);
    dreq = 1'b0;               // low before the end of the first cycle
    check(bus_addr == 32'h500, "R6", "first address", bus_addr, 32'h500);
    measure_high(hi);
    check(hi == CYC_LEN, "R2", "dack length", hi, CYC_LEN);
    expect_quiet(12, "R6");
    cfg_read(2'd1, v); check(v == 4, "R6", "count kept", v, 4);
    cfg_read(2'd0, v); check(v == 32'h502, "R6", "address kept", v, 32'h502);
    cfg_read(2'd2, v); check(v[0], "R6", "enable kept", v, 32'h15);
    dreq = 1'b1;
    watch_cycles(4, 32'h502, 32'd2, 1'b0, "R6");
    @(negedge clk);
    check(done, "R5", "done after resume", done, 1);
    dreq = 1'b0;
    cfg_write(2'd2, 32'h80);
  endtask

  task automatic t_gate();
    logic [31:0] v;
    cfg_write(2'd1, 32'd0);
    dreq = 1'b1;
    cfg_write(2'd2, 32'h01);   // enabled but nothing to move
    expect_quiet(15, "R8");
    check(!done, "R8", "no done with zero count", done, 0);
    cfg_write(2'd2, 32'h00);
    cfg_write(2'd1, 32'd2);    // units pending, channel disabled
    expect_quiet(15, "R8");
    cfg_read(2'd1, v); check(v == 2, "R8", "count untouched", v, 2);
    dreq = 1'b0;
  endtask

  task automatic t_busy_write();
    logic [31:0] v;
    bit seen;
    cfg_write(2'd0, 32'h800);
    cfg_write(2'd1, 32'd3);
    dreq = 1'b1;
    cfg_write(2'd2, 32'h19);   // en, size 4B, increment
    wait_dack("R10", seen);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'hFFF0;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    cfg_write(2'd1, 32'h77);
    watch_cycles(2, 32'h804, 32'd4, 1'b0, "R10");
    cfg_read(2'd1, v); check(v == 0, "R10", "count write ignored", v, 0);
    cfg_read(2'd0, v); check(v == 32'h80C, "R10", "address write ignored", v, 32'h80C);
    dreq = 1'b0;
    cfg_write(2'd2, 32'h80);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_inc_write();
    t_dec_read();
    t_modes();
    t_req_drop();
    t_gate();
    t_busy_write();
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule